// File: doc/BRIEF.md
# Reloadable Interval Timer with Snapshot Byte Readout

This block is a reloadable up-counting interval timer that sits behind an 8-bit register bus with separate write and read strobes and a 3-bit address. Software loads a terminal value in three byte writes, turns counting and the interrupt on through a control register, and reads the running count through latch bytes that capture the whole counter in one step, so a multi-byte read cannot mix two different count values.

The count advances on a one-cycle tick enable made from the bus clock. When the speed strap is low the tick is present on every bus cycle. When the strap is high the bus clock is twice the count rate, so the tick is present on every second cycle. Each time the count passes its terminal value it restarts from zero and raises a level interrupt. Software acknowledges the interrupt by clearing and then setting the interrupt-enable bit. The counter width is a parameter: 22 bits by default, and 19 bits for narrower builds.

Top module: `ivt_top`

## Requirements
- R1: With `fast_i` low the counter advances once per bus clock while counting is enabled. With `fast_i` high it advances once every two bus clocks.
- R2: While enabled, the counter steps up from 0. On the tick where it equals the active terminal value it returns to 0 and sets the pending flag, so one period is terminal+1 ticks.
- R3: Address 4 is the control register: bit 0 enables counting and bit 1 enables the interrupt. Reads return those bits with bits 7:2 zero. While bit 0 is low the counter stays at 0.
- R4: Writes to address 0 load terminal bits 7:0, to address 1 bits 15:8, and to address 2 (data bits 5:0) bits 21:16. A write to address 3 changes nothing. A new terminal value takes effect at the next wrap, or at once while counting is disabled.
- R5: A read of address 0 returns the low byte of the live count and captures the whole count into the snapshot. Reads of addresses 1 to 3 return fields of the last snapshot and leave it unchanged.
- R6: Bytes for addresses 0, 1 and 2 carry count bits 5:0, 11:6 and 17:12 respectively. Within each byte, bits 4:0 hold the low five bits of that group, bit 6 holds its sixth bit, and bits 5 and 7 read 0. The address 3 byte carries count bits 21:18 in bits 3:0, and its upper nibble reads 0.
- R7: `irq_o` is the pending flag ANDed with the interrupt-enable bit. The pending flag is cleared in every cycle in which the interrupt enable is low. Setting the enable again re-arms the interrupt for the next wrap.
- R8: Read data appears on `rdata_o` in the cycle after the read strobe and then holds. Addresses 5 to 7 read as 0.
- R9: Reset clears the counter, the snapshot, the terminal value, both enable bits, the pending flag and `rdata_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fast_i | input | 1 | Speed strap: high when the bus clock is twice the count rate |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe, one cycle per access |
| rd_i | input | 1 | Read strobe, one cycle per access |
| rdata_o | output | 8 | Registered read data |
| irq_o | output | 1 | Level timer interrupt |

## Verification
The hardest case to reach from the ports is a new terminal value written while the counter is running. When that value is lower than the current count, the period must finish with the old terminal value. A second hard case is an interrupt-enable clear that lands in the same cycle as a wrap. Random stimulus keeps the upper terminal bytes mostly zero, so wraps come often, and scatters terminal and control writes between them. A reference model in the bench tracks the active terminal value separately from the written one. A long directed run with the largest terminal value lets the count reach bit 17, so the bit placement in the upper latch bytes is checked with nonzero data.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  localparam int FULL_W = 22;
  localparam int GRP_W  = 6;

  typedef enum logic [2:0] {
    A_LAT0 = 3'd0,
    A_LAT1 = 3'd1,
    A_LAT2 = 3'd2,
    A_LAT3 = 3'd3,
    A_CTRL = 3'd4
  } ivt_addr_e;

  // six count bits spread over a byte: [4:0] low, [6] sixth, [5],[7] zero
  function automatic logic [7:0] grp_byte(logic [GRP_W-1:0] g);
    return {1'b0, g[5], 1'b0, g[4:0]};
  endfunction
endpackage

// File: rtl/ivt_tick_gen.sv
module ivt_tick_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fast_i,
  output logic tick_o
);
  logic phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= 1'b0;
    else         phase_q <= fast_i ? ~phase_q : 1'b0;
  end

  assign tick_o = ~fast_i | phase_q;
endmodule

// File: rtl/ivt_counter.sv
module ivt_counter #(
  parameter int CNT_W = 22
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             cen_i,
  input  logic             ien_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] term_o,
  output logic             pend_o
);
  logic [CNT_W-1:0] cnt_q, term_q;
  logic             pend_q;
  logic             at_term, wrap;

  assign at_term = (cnt_q == term_q);
  assign wrap    = cen_i & tick_i & at_term;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      term_q <= '0;
    end else if (!cen_i) begin
      cnt_q  <= '0;
      term_q <= reload_i;
    end else if (tick_i) begin
      if (at_term) begin
        cnt_q  <= '0;
        term_q <= reload_i;   // shadow: written value applies from here
      end else begin
        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_q <= 1'b0;
    else if (!ien_i) pend_q <= 1'b0;
    else if (wrap)   pend_q <= 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign term_o = term_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/ivt_regs.sv
module ivt_regs
  import ivt_pkg::*;
#(
  parameter int CNT_W = 22
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [2:0]              addr_i,
  input  logic [7:0]              wdata_i,
  input  logic                    wr_i,
  input  logic                    rd_i,
  input  logic [CNT_W-1:0]        cnt_i,
  output logic [CNT_W-1:0]        reload_o,
  output logic                    cen_o,
  output logic                    ien_o,
  output logic [FULL_W-1:GRP_W]   snap_o,
  output logic [7:0]              rdata_o
);
  localparam int NGRP = 3;

  logic [CNT_W-1:0]          reload_q;
  logic                      cen_q, ien_q;
  logic [FULL_W-1:GRP_W]     snap_q;
  logic [7:0]                rdata_q, rd_next;
  logic [FULL_W-1:0]         cnt_ext, rl_next;
  logic [7:0]                snap_byte [1:NGRP-1];

  assign cnt_ext = FULL_W'(cnt_i);

  for (genvar g = 1; g < NGRP; g++) begin : g_grp
    assign snap_byte[g] = grp_byte(snap_q[g*GRP_W +: GRP_W]);
  end

  always_comb begin
    rl_next = FULL_W'(reload_q);
    case (addr_i)
      A_LAT0:  rl_next[7:0]   = wdata_i;
      A_LAT1:  rl_next[15:8]  = wdata_i;
      A_LAT2:  rl_next[21:16] = wdata_i[5:0];
      default: ;
    endcase
  end

  always_comb begin
    case (addr_i)
      A_LAT0:  rd_next = grp_byte(cnt_ext[GRP_W-1:0]);
      A_LAT1:  rd_next = snap_byte[1];
      A_LAT2:  rd_next = snap_byte[2];
      A_LAT3:  rd_next = {4'b0, snap_q[FULL_W-1:3*GRP_W]};
      A_CTRL:  rd_next = {6'b0, ien_q, cen_q};
      default: rd_next = 8'h00;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_q <= '0;
      cen_q    <= 1'b0;
      ien_q    <= 1'b0;
    end else if (wr_i) begin
      if (addr_i == A_CTRL) begin
        cen_q <= wdata_i[0];
        ien_q <= wdata_i[1];
      end else begin
        reload_q <= rl_next[CNT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_q  <= '0;
      rdata_q <= '0;
    end else if (rd_i) begin
      rdata_q <= rd_next;
      if (addr_i == A_LAT0) snap_q <= cnt_ext[FULL_W-1:GRP_W];
    end
  end

  assign reload_o = reload_q;
  assign cen_o    = cen_q;
  assign ien_o    = ien_q;
  assign snap_o   = snap_q;
  assign rdata_o  = rdata_q;
endmodule

// File: rtl/ivt_top.sv
module ivt_top
  import ivt_pkg::*;
#(
  parameter int CNT_W = 22
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       fast_i,
  input  logic [2:0] addr_i,
  input  logic [7:0] wdata_i,
  input  logic       wr_i,
  input  logic       rd_i,
  output logic [7:0] rdata_o,
  output logic       irq_o
);
  logic                  tick, cen, ien, pend;
  logic [CNT_W-1:0]      cnt, term, reload;
  logic [FULL_W-1:GRP_W] snap;

  ivt_tick_gen u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fast_i (fast_i),
    .tick_o (tick)
  );

  ivt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .cen_i    (cen),
    .ien_i    (ien),
    .reload_i (reload),
    .cnt_o    (cnt),
    .term_o   (term),
    .pend_o   (pend)
  );

  ivt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .wr_i     (wr_i),
    .rd_i     (rd_i),
    .cnt_i    (cnt),
    .reload_o (reload),
    .cen_o    (cen),
    .ien_o    (ien),
    .snap_o   (snap),
    .rdata_o  (rdata_o)
  );

  assign irq_o = pend & ien;
endmodule

// File: rtl/ivt_checker.sv
module ivt_checker
  import ivt_pkg::*;
#(
  parameter int CNT_W = 22
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  fast_i,
  input logic [2:0]            addr_i,
  input logic                  rd_i,
  input logic                  tick,
  input logic                  cen,
  input logic                  ien,
  input logic                  pend,
  input logic                  irq_o,
  input logic [CNT_W-1:0]      cnt,
  input logic [CNT_W-1:0]      term,
  input logic [FULL_W-1:GRP_W] snap
);
  logic [FULL_W-1:0] cnt_x;
  assign cnt_x = FULL_W'(cnt);

  p_tick_alt_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fast_i && tick) |=> (!tick || !fast_i));

  p_in_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cen |-> (cnt <= term));

  p_wrap_pend_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cen && tick && cnt == term && ien) |=> pend);

  p_hold_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cen |=> (cnt == '0));

  p_snap_take_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == 3'd0) |=> (snap == $past(cnt_x[FULL_W-1:GRP_W])));

  p_snap_keep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i && addr_i == 3'd0) |=> $stable(snap));

  p_irq_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ien);

  p_ack_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ien |=> !pend);
endmodule

bind ivt_top ivt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .fast_i (fast_i),
  .addr_i (addr_i),
  .rd_i   (rd_i),
  .tick   (tick),
  .cen    (cen),
  .ien    (ien),
  .pend   (pend),
  .irq_o  (irq_o),
  .cnt    (cnt),
  .term   (term),
  .snap   (snap)
);

// File: tb/sim_ivt_top.sv
`timescale 1ns/1ps
module sim_ivt_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fast = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] rdata;
  logic       irq;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ivt_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .fast_i(fast), .addr_i(addr),
    .wdata_i(wdata), .wr_i(wr), .rd_i(rd), .rdata_o(rdata), .irq_o(irq)
  );

  // reference model built from the requirements
  logic [21:0] m_cnt, m_term, m_rl, m_snap;
  logic        m_cen, m_ien, m_pend, m_ph;
  logic [7:0]  m_rdata;

  function automatic logic [7:0] exp_byte(logic [21:0] c, logic [21:0] s, int a,
                                          logic ce, logic ie);
    logic [5:0] g;
    case (a)
      0: begin g = c[5:0];   return {1'b0, g[5], 1'b0, g[4:0]}; end
      1: begin g = s[11:6];  return {1'b0, g[5], 1'b0, g[4:0]}; end
      2: begin g = s[17:12]; return {1'b0, g[5], 1'b0, g[4:0]}; end
      3: return {4'b0, s[21:18]};
      4: return {6'b0, ie, ce};
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= '0; m_term <= '0; m_rl <= '0; m_snap <= '0;
      m_cen <= 0; m_ien <= 0; m_pend <= 0; m_ph <= 0; m_rdata <= '0;
    end else begin
      logic t, w;
      t = !fast || m_ph;
      w = m_cen && t && (m_cnt == m_term);
      m_ph <= fast ? !m_ph : 1'b0;
      if (!m_cen) begin m_cnt <= '0; m_term <= m_rl; end
      else if (t) begin
        if (m_cnt == m_term) begin m_cnt <= '0; m_term <= m_rl; end
        else m_cnt <= m_cnt + 1;
      end
      if (!m_ien) m_pend <= 0; else if (w) m_pend <= 1;
      if (wr) begin
        case (addr)
          0: m_rl[7:0]   <= wdata;
          1: m_rl[15:8]  <= wdata;
          2: m_rl[21:16] <= wdata[5:0];
          4: begin m_cen <= wdata[0]; m_ien <= wdata[1]; end
          default: ;
        endcase
      end
      if (rd) begin
        m_rdata <= exp_byte(m_cnt, m_snap, int'(addr), m_cen, m_ien);
        if (addr == 0) m_snap <= m_cnt;
      end
    end
  end

  task automatic check8(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  // R7: interrupt level compared every cycle
  always @(negedge clk) begin
    if (rst_n && !done) check8("R7 irq", {7'b0, irq}, {7'b0, m_pend & m_ien});
  end

  task automatic bus_wr(int a, logic [7:0] d);
    @(negedge clk); addr = 3'(a); wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  function automatic string tag_of(int a);
    case (a)
      0: return "R5 lat0";
      1, 2: return "R6 lat";
      3: return "R6 lat3";
      4: return "R3 ctrl";
      default: return "R8 unmapped";
    endcase
  endfunction

  task automatic bus_rd(int a);
    @(negedge clk); addr = 3'(a); rd = 1'b1;
    @(negedge clk); rd = 1'b0;
    check8(tag_of(a), rdata, m_rdata);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h1d2c);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9: reset state
    check8("R9 rdata", rdata, 8'h00);
    check8("R9 irq", {7'b0, irq}, 8'h00);
    bus_rd(4);
    bus_rd(0);
    check8("R9 lat0 zero", rdata, 8'h00);

    // R2: terminal 3, interrupt 4 ticks after enabling
    bus_wr(0, 8'h03);
    bus_wr(4, 8'h03);
    idle(3);
    check8("R2 no irq before wrap", {7'b0, irq}, 8'h00);
    idle(1);
    check8("R2 irq at wrap", {7'b0, irq}, 8'h01);

    // R7: acknowledge by clearing then setting ien
    bus_wr(4, 8'h01);
    check8("R7 cleared", {7'b0, irq}, 8'h00);
    bus_wr(4, 8'h03);
    idle(6);

    // R4: address 3 write ignored, shorter terminal while running
    bus_wr(3, 8'hff);
    bus_wr(0, 8'h40);
    idle(20);
    bus_wr(0, 8'h02);
    idle(50);
    bus_rd(4);

    // R1: fast strap
    @(negedge clk); fast = 1'b1;
    bus_wr(4, 8'h00);
    bus_wr(0, 8'hff); bus_wr(1, 8'hff); bus_wr(2, 8'hff);
    bus_wr(4, 8'h01);
    idle(37);
    for (int a = 0; a < 8; a++) bus_rd(a);
    @(negedge clk); fast = 1'b0;
    idle(11);
    for (int a = 0; a < 5; a++) bus_rd(a);

    // R6: long run so bits up to 17 become nonzero
    idle(135000);
    for (int a = 0; a < 4; a++) bus_rd(a);
    bus_rd(2); bus_rd(1);

    // random mix with short terminals
    bus_wr(4, 8'h00);
    bus_wr(1, 8'h00); bus_wr(2, 8'h00);
    for (int i = 0; i < 3000; i++) begin
      int op;
      op = $urandom_range(0, 9);
      case (op)
        0, 1: bus_wr($urandom_range(0, 4), 8'($urandom_range(0, 40)));
        2:    bus_wr(4, 8'($urandom_range(0, 3)));
        3:    bus_wr($urandom_range(1, 2), ($urandom_range(0, 7) == 0) ? 8'h01 : 8'h00);
        4:    begin @(negedge clk); fast = 1'($urandom_range(0, 1)); end
        5, 6, 7: bus_rd($urandom_range(0, 7));
        default: idle($urandom_range(1, 12));
      endcase
    end
    bus_wr(4, 8'h03);
    idle(60);
    bus_rd(0); bus_rd(1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (199000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule